// File: doc/BRIEF.md
# Iterative Logical Right Shifter

This block shifts a data word right by a variable amount, one bit position per clock cycle, with zeros entering at the most significant end. It does not use a barrel shifter. A small down-counter holds the remaining shift distance. The counter is loaded, tested for zero and decremented once for every single-bit step.

The shift distance is chosen in two stages. First the counter is loaded from a constant count field that is supplied with the request. If that value is zero, the counter is then reloaded from the low bits of a register count input. Because of this, a zero constant means "take the distance from the register". A request is made by pulsing `start_i` while the unit is idle. The operand and both count inputs are captured on the same edge. When the loop has finished, `done_o` pulses for one cycle and `result_o` holds the shifted word.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start_i`. The transition on start is named *accept*.
- `ST_LOAD_CONST`: loads the counter from the captured constant field.
- `ST_LOAD_REG`: reloads the counter from the captured register count, but only when the counter is zero.
- `ST_COPY`: copies the operand, unchanged, into the result register.
- `ST_SHIFT`: while the counter is nonzero, each cycle performs one step (shift right by one, counter minus one) and stays in this state. The transition named *exit* moves on to `ST_DONE` when the counter is zero.
- `ST_DONE`: raises `done_o` for one cycle and returns to `ST_IDLE`.

Top module: `shr_iter_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `result_o` is zero.
- R2: When the constant count field is nonzero, the shift distance equals that field, and the register count has no effect on the result.
- R3: When the constant count field is zero, the shift distance equals the register count input.
- R4: The result equals the captured operand shifted right logically by the chosen distance. Each vacated upper bit is filled with 0.
- R5: `done_o` is high in the cycle that follows the (4 + n)-th rising edge after the accepting edge, where n is the shift distance.
- R6: When both count inputs are zero, the result equals the operand and `done_o` follows after exactly 4 cycles, with no shift step taken.
- R7: `done_o` is high for exactly one cycle. `busy_o` is high from the accepting edge up to and including the done cycle, and is low in the cycle after it.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the result nor the latency of the operation in progress.
- R9: `result_o` stays unchanged after the done cycle until another request is accepted.
- R10: The operand and both count inputs are sampled only on the accepting edge. Changing them later has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted only when idle |
| operand_i | input | DATA_W (32) | Word to be shifted |
| const_cnt_i | input | CNT_W (5) | Constant shift distance; zero selects the register count |
| reg_cnt_i | input | CNT_W (5) | Fallback shift distance |
| busy_o | output | 1 | High while a request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W (32) | Shifted word, held after completion |

## Verification
The embedded properties assume that `rst_n` is applied before any request is made. They also rely on the controller never asking the counter to decrement at zero and never asking it to load and decrement in the same cycle. The rules on held data assume that the capture and step controls come only from the state machine. The stimulus drives every input only at the falling clock edge, keeps `start_i` high for exactly one cycle per request, and deliberately raises `start_i` again during a busy period and changes the data inputs after acceptance. This exercises the ignore and capture rules without breaking any of those assumptions.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_CONST,
        ST_LOAD_REG,
        ST_COPY,
        ST_SHIFT,
        ST_DONE
    } shr_state_e;

    // Number of non-shift cycles between the accepting edge and done.
    localparam int unsigned SETUP_CYCLES = 4;

endpackage

// File: rtl/shr_input_hold.sv
module shr_input_hold #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  const_cnt_i,
    input  logic [CNT_W-1:0]  reg_cnt_i,
    output logic [DATA_W-1:0] operand_o,
    output logic [CNT_W-1:0]  const_cnt_o,
    output logic [CNT_W-1:0]  reg_cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            operand_o   <= '0;
            const_cnt_o <= '0;
            reg_cnt_o   <= '0;
        end else if (capture_i) begin
            operand_o   <= operand_i;
            const_cnt_o <= const_cnt_i;
            reg_cnt_o   <= reg_cnt_i;
        end
    end

    // R10: captured values move only on a capture cycle
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> ($stable(operand_o) && $stable(const_cnt_o) && $stable(reg_cnt_o)));

endmodule

// File: rtl/shr_down_counter.sv
module shr_down_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= load_val_i;
        end else if (dec_i) begin
            cnt_o <= cnt_o - CNT_W'(1);
        end
    end

    assign zero_o = (cnt_o == '0);

    // R4: one decrement per shift step
    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1)));

    // R4: the controller never steps past zero
    a_r4_no_dec_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> !zero_o);

    a_r4_load_dec_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && dec_i));

endmodule

// File: rtl/shr_result_reg.sv
module shr_result_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              copy_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] res_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o <= '0;
        end else if (copy_i) begin
            res_o <= data_i;
        end else if (step_i) begin
            res_o <= {1'b0, res_o[DATA_W-1:1]};
        end
    end

    // R4: a step moves every bit down one place with zero fill
    a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !copy_i) |=> (res_o == {1'b0, $past(res_o[DATA_W-1:1])}));

    // R9: the result holds when neither control is active
    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy_i && !step_i) |=> $stable(res_o));

endmodule

// File: rtl/shr_seq_ctrl.sv
module shr_seq_ctrl
    import shr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cnt_zero_i,
    output logic capture_o,
    output logic load_o,
    output logic load_sel_o,
    output logic dec_o,
    output logic copy_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    shr_state_e state_q;
    shr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_LOAD_CONST;
            ST_LOAD_CONST: state_d = ST_LOAD_REG;
            ST_LOAD_REG:   state_d = ST_COPY;
            ST_COPY:       state_d = ST_SHIFT;
            ST_SHIFT:      if (cnt_zero_i) state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o  = 1'b0;
        load_o     = 1'b0;
        load_sel_o = 1'b0;
        dec_o      = 1'b0;
        copy_o     = 1'b0;
        step_o     = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                capture_o = start_i;
            end
            ST_LOAD_CONST: begin
                load_o = 1'b1;
            end
            ST_LOAD_REG: begin
                load_o     = cnt_zero_i;
                load_sel_o = 1'b1;
            end
            ST_COPY: begin
                copy_o = 1'b1;
            end
            ST_SHIFT: begin
                step_o = !cnt_zero_i;
                dec_o  = !cnt_zero_i;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: idle follows the done cycle
    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R8: a start while busy never restarts the sequence
    a_r8_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state_q != ST_LOAD_CONST));

    // R5: the loop exits on the cycle the counter reads zero
    a_r5_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_zero_i) |=> done_o);

endmodule

// File: rtl/shr_iter_unit.sv
module shr_iter_unit #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  const_cnt_i,
    input  logic [CNT_W-1:0]  reg_cnt_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);

    logic              capture;
    logic              load;
    logic              load_sel;
    logic              dec;
    logic              copy;
    logic              step;
    logic              cnt_zero;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  load_val;
    logic [DATA_W-1:0] op_hold;
    logic [CNT_W-1:0]  const_hold;
    logic [CNT_W-1:0]  reg_hold;

    shr_input_hold #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .operand_i  (operand_i),
        .const_cnt_i(const_cnt_i),
        .reg_cnt_i  (reg_cnt_i),
        .operand_o  (op_hold),
        .const_cnt_o(const_hold),
        .reg_cnt_o  (reg_hold)
    );

    assign load_val = load_sel ? reg_hold : const_hold;

    shr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(load_val),
        .dec_i     (dec),
        .cnt_o     (cnt),
        .zero_o    (cnt_zero)
    );

    shr_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .copy_i(copy),
        .data_i(op_hold),
        .step_i(step),
        .res_o (result_o)
    );

    shr_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .cnt_zero_i(cnt_zero),
        .capture_o (capture),
        .load_o    (load),
        .load_sel_o(load_sel),
        .dec_o     (dec),
        .copy_o    (copy),
        .step_o    (step),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    // R3: the register count is taken only when the constant loaded as zero
    a_r3_fallback_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_sel) |-> (const_hold == '0));

    // R2: a nonzero constant survives the fallback stage
    a_r2_const_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_sel && const_hold != '0) |=> ##1 (cnt == $past(const_hold, 2)));

endmodule

// File: tb/shr_iter_unit_bench.sv
module shr_iter_unit_bench;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DATA_W-1:0] operand_i = '0;
    logic [CNT_W-1:0]  const_cnt_i = '0;
    logic [CNT_W-1:0]  reg_cnt_i = '0;
    logic              busy_o;
    logic              done_o;
    logic [DATA_W-1:0] result_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shr_iter_unit #(.DATA_W(DATA_W)) u_shr_iter_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .operand_i  (operand_i),
        .const_cnt_i(const_cnt_i),
        .reg_cnt_i  (reg_cnt_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .result_o   (result_o)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] op, input logic [4:0] c, input logic [4:0] r,
                          input bit poke, input string tag);
        int n;
        int cyc;
        logic [31:0] exp;
        n   = (c != 0) ? int'(c) : int'(r);
        exp = op >> n;
        @(negedge clk);
        operand_i   = op;
        const_cnt_i = c;
        reg_cnt_i   = r;
        start_i     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i     = 1'b0;
        operand_i   = ~op;          // R10: later changes must not matter
        const_cnt_i = ~c;
        reg_cnt_i   = ~r;
        chk(busy_o == 1'b1, {tag, " R7 busy after accept"}, 32'(busy_o), 32'd1);
        cyc = 0;
        while (!done_o && cyc < 100) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
            start_i = (poke && cyc == 2);   // R8: start while busy
            if (poke && cyc == 2) operand_i = 32'hDEAD_BEEF;
        end
        start_i = 1'b0;
        chk(cyc == 4 + n, {tag, " R5 latency"}, 32'(cyc), 32'(4 + n));
        chk(result_o == exp, {tag, " R4 result"}, result_o, exp);
        @(posedge clk);
        @(negedge clk);
        chk(done_o == 1'b0 && busy_o == 1'b0, {tag, " R7 done one cycle"},
            {30'd0, done_o, busy_o}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(result_o == exp, {tag, " R9 result held"}, result_o, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF;
        pats[1] = 32'h8000_0001;
        pats[2] = 32'hA5C3_5A3C;
        pats[3] = 32'h1234_5678;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(busy_o == 1'b0, "R1 busy at reset", 32'(busy_o), 32'd0);
        chk(done_o == 1'b0, "R1 done at reset", 32'(done_o), 32'd0);
        chk(result_o == '0, "R1 result at reset", result_o, 32'd0);
        rst_n = 1'b1;

        // R2: every nonzero constant, register count set to a distracting value
        for (int c = 1; c < 32; c++) begin
            for (int p = 0; p < 2; p++) begin
                run_op(pats[(c + p) % 4], 5'(c), 5'(31 - c), 1'b0, "R2");
            end
        end

        // R3: constant zero, every register count
        for (int r = 1; r < 32; r++) begin
            for (int p = 0; p < 2; p++) begin
                run_op(pats[(r + p + 1) % 4], 5'd0, 5'(r), 1'b0, "R3");
            end
        end

        // R6: both counts zero
        for (int p = 0; p < 4; p++) begin
            run_op(pats[p], 5'd0, 5'd0, 1'b0, "R6");
        end

        // R8: start pulses during busy periods
        run_op(32'hFFFF_FFFF, 5'd31, 5'd3, 1'b1, "R8");
        run_op(32'hF0F0_F0F0, 5'd0, 5'd7, 1'b1, "R8");
        run_op(32'h0000_0001, 5'd0, 5'd0, 1'b1, "R8");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule